// File: doc/BRIEF.md
# Lockable Watchdog Timer with Control Register

This block is the watchdog timer of a small microcontroller. It advances only on cycles where an input enable pulse is high; that pulse arrives at one twelfth of the oscillator rate. The enable pulse drives an 8-bit prescaler. The prescaler has a selectable power-of-two tap, and that tap advances a 15-bit counter. When the counter rolls over, the block sends a one-cycle reset request to the CPU and sets a sticky overflow flag. Firmware must write the restart bit often enough to stop the counter from ever rolling over.

All control goes through one 8-bit register. The register has a write strobe and write data, and its contents can always be read. The register holds the overflow flag, an enable bit, a restart bit and an idle-run bit. The enable bit can be set but never cleared. The restart bit clears itself. The idle-run bit decides whether counting goes on while the CPU is idle. The register also holds a 3-bit prescale select. At power-on the register loads an initial byte from an input port, which stands in for a nonvolatile option byte. This lets the watchdog already be running when the CPU leaves reset. Later watchdog-caused resets of the CPU do not reach this block, so the overflow flag is still readable after such a reset.

Top module: `lockwd_top`

## Requirements
- R1: While `rst_n` is low, the register loads `opt_init`. Reading it then gives `opt_init` with bit 6 and bit 4 forced to 0. For example, `opt_init` = 8'hFF reads back as 8'hAF.
- R2: While the enable bit (bit 5) is 0, the prescaler and the counter hold their values and no reset request is raised.
- R3: Once bit 5 is 1, it stays 1 until the next power-on reset. Writing 0 to bit 5 neither clears the bit nor stops counting.
- R4: With prescale select n in bits 2:0, the reset request follows exactly 2^(n+1) x 2^CNT_W counting cycles after a restart. With the default CNT_W of 15 and n = 0, that is 65536 cycles.
- R5: A write with bit 4 = 1 clears the prescaler and the counter at that clock edge, and no counting takes place on that edge. Bit 4 and bit 6 always read as 0.
- R6: When the counter rolls over, `wd_reset_req` is high for exactly one cycle. Bit 7 (the overflow flag) is set at the same edge.
- R7: The overflow flag is cleared only by a write with bit 7 = 0. A write with bit 7 = 1 has no effect on it. If a rollover and a clearing write occur at the same edge, the flag is set.
- R8: While `cpu_idle` is high, counting holds if bit 3 is 0 and continues if bit 3 is 1.
- R9: After a rollover, the counter restarts from zero and keeps counting. The next request follows exactly one full period later.
- R10: The block counts only on cycles where `tick_en` is high. Cycles with `tick_en` low do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low power-on reset; loads the register from `opt_init` |
| tick_en | input | 1 | Count enable pulse at one twelfth of the oscillator rate |
| cpu_idle | input | 1 | High while the CPU is in idle mode |
| opt_init | input | 8 | Power-on value of the control register (option byte) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| wd_reset_req | output | 1 | One-cycle reset request to the CPU |

## Verification
The assertions check the following on every cycle:
- The enable bit never drops once it is set.
- The request never lasts two cycles, and it always comes with the flag set.
- The flag rises only with a request and falls only on a clearing write.
- A restart leaves the counter and prescaler at zero.
- The count is frozen whenever the block is disabled, `tick_en` is low, or the CPU is idle without the idle-run bit set.
- The unused bits read as zero.

Only the bench scenarios can show the exact period for each prescale select, the timing of the 15-bit rollover, and that a restart or an idle stretch moves the next request by the expected number of cycles. The bench also checks that writing 1 to bit 7 leaves a cleared flag cleared.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;
   localparam int SEL_W    = 3;
   localparam int REG_W    = 8;
   localparam int FLAG_BIT = 7;
   localparam int EN_BIT   = 5;
   localparam int RSTR_BIT = 4;
   localparam int IDLE_BIT = 3;

   typedef struct packed {
      logic             flag;
      logic             en;
      logic             idle_run;
      logic [SEL_W-1:0] sel;
   } ctl_t;

   function automatic logic [REG_W-1:0] pack_rd(input ctl_t c);
      return {c.flag, 1'b0, c.en, 1'b0, c.idle_run, c.sel};
   endfunction
endpackage

// File: rtl/lockwd_regs.sv
module lockwd_regs
   import lockwd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] opt_init,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             ovf_set,
   output ctl_t             ctl,
   output logic             restart,
   output logic [REG_W-1:0] rd_data
);
   ctl_t ctl_q;
   logic unused_bits;
   assign unused_bits = wr_data[6] ^ opt_init[6] ^ opt_init[RSTR_BIT];

   assign restart = wr_en & wr_data[RSTR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q.flag     <= opt_init[FLAG_BIT];
         ctl_q.en       <= opt_init[EN_BIT];
         ctl_q.idle_run <= opt_init[IDLE_BIT];
         ctl_q.sel      <= opt_init[SEL_W-1:0];
      end else begin
         if (ovf_set)
            ctl_q.flag <= 1'b1;
         else if (wr_en && !wr_data[FLAG_BIT])
            ctl_q.flag <= 1'b0;
         if (wr_en) begin
            ctl_q.en       <= ctl_q.en | wr_data[EN_BIT];
            ctl_q.idle_run <= wr_data[IDLE_BIT];
            ctl_q.sel      <= wr_data[SEL_W-1:0];
         end
      end
   end

   assign ctl     = ctl_q;
   assign rd_data = pack_rd(ctl_q);

   // R3: enable is one-time
   p_en_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.en |=> ctl_q.en);
   // R7: flag falls only on a clearing write
   p_flag_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_q.flag) |-> $past(wr_en && !wr_data[FLAG_BIT]));
   // R5: reserved and self-clearing bits read zero
   p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[6] == 1'b0) && (rd_data[RSTR_BIT] == 1'b0));
endmodule

// File: rtl/lockwd_prescale.sv
module lockwd_prescale #(
   parameter int PRE_W = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [SEL_W-1:0] sel,
   output logic             tick,
   output logic [PRE_W-1:0] pre_q
);
   localparam int TAPS = 1 << SEL_W;
   logic [TAPS-1:0] tap_full;

   generate
      for (genvar i = 0; i < TAPS; i++) begin : g_tap
         assign tap_full[i] = &pre_q[i:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (clr)
         pre_q <= '0;
      else if (step)
         pre_q <= pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
   end

   assign tick = step & ~clr & tap_full[sel];
endmodule

// File: rtl/lockwd_count.sv
module lockwd_count #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic             wrap,
   output logic [CNT_W-1:0] cnt_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
   end

   assign wrap = step & ~clr & (&cnt_q);
endmodule

// File: rtl/lockwd_top.sv
module lockwd_top
   import lockwd_pkg::*;
#(
   parameter int PRE_W = 8,
   parameter int CNT_W = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       cpu_idle,
   input  logic [7:0] opt_init,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   output logic       wd_reset_req
);
   generate
      if (PRE_W < (1 << SEL_W)) begin : g_bad_pre
         $error("PRE_W too narrow for every prescale tap");
      end
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
   endgenerate

   ctl_t             ctl;
   logic             restart;
   logic             count_ok;
   logic             pre_tick;
   logic             wrap;
   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt_q;
   logic             req_q;

   lockwd_regs u_regs (
      .clk(clk), .rst_n(rst_n), .opt_init(opt_init), .wr_en(wr_en),
      .wr_data(wr_data), .ovf_set(wrap), .ctl(ctl), .restart(restart),
      .rd_data(rd_data)
   );

   assign count_ok = ctl.en & tick_en & (~cpu_idle | ctl.idle_run);

   lockwd_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(restart), .step(count_ok),
      .sel(ctl.sel), .tick(pre_tick), .pre_q(pre_q)
   );

   lockwd_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(restart), .step(pre_tick),
      .wrap(wrap), .cnt_q(cnt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= wrap;
   end
   assign wd_reset_req = req_q;

   // R6: request is a single cycle and comes with the flag set
   p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wd_reset_req |=> !wd_reset_req);
   p_req_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wd_reset_req |-> rd_data[FLAG_BIT]);
   // R7: flag rises only together with a request
   p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[FLAG_BIT]) |-> wd_reset_req);
   // R5: restart leaves the chain at zero
   p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0) && (pre_q == '0));
   // R2: disabled chain holds
   p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data[EN_BIT] && !restart) |=> $stable(cnt_q) && $stable(pre_q));
   // R10: no tick, no count
   p_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !restart) |=> $stable(cnt_q) && $stable(pre_q));
   // R8: idle without idle-run holds
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_idle && !rd_data[IDLE_BIT] && !restart) |=> $stable(cnt_q) && $stable(pre_q));
endmodule

// File: tb/lockwd_top_bench.sv
`timescale 1ns/1ps
module lockwd_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       cpu_idle = 1'b0;
   logic [7:0] opt_init = 8'h00;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_m, rd_s;
   logic       req_m, req_s;
   int         checks = 0;
   int         errors = 0;

   localparam int NS = 2 * 16;

   always #2 clk = ~clk;

   lockwd_top u_lockwd_top (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_idle(cpu_idle),
      .opt_init(opt_init), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_m), .wd_reset_req(req_m)
   );
   lockwd_top #(.CNT_W(4)) u_lockwd_top_small (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_idle(cpu_idle),
      .opt_init(opt_init), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_s), .wd_reset_req(req_s)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [7:0] opt);
      @(negedge clk);
      opt_init = opt;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic req_of(input bit big);
      return big ? req_m : req_s;
   endfunction

   // request expected on the n-th edge from now; consumes n+1 edges
   task automatic expect_req(input bit big, input int n, input string tag);
      repeat (n - 1) @(posedge clk);
      @(negedge clk);
      chk({tag, " req low before period end"}, req_of(big), 1'b0);
      @(posedge clk);
      @(negedge clk);
      chk({tag, " req high at period end"}, req_of(big), 1'b1);
      @(posedge clk);
      @(negedge clk);
      chk({tag, " req one cycle wide R6"}, req_of(big), 1'b0);
   endtask

   task automatic t_power_on();
      do_reset(8'h00);
      chk("R1 reset value zero", rd_m, 8'h00);
      do_reset(8'hFF);
      chk("R1 reset value FF", rd_m, 8'hAF);
      chk("R1 reset value FF small", rd_s, 8'hAF);
      do_reset(8'h00);
   endtask

   task automatic t_disabled();
      int seen = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (req_s || req_m) seen++;
      end
      chk("R2 no request while disabled", seen, 0);
      chk("R2 enable still clear", rd_s[5], 1'b0);
   endtask

   task automatic t_ratio();
      wr(8'h30);
      expect_req(1'b0, NS, "R4 sel0");
      chk("R6 flag set after overflow", rd_s[7], 1'b1);
      wr(8'h32);
      expect_req(1'b0, 8 * 16, "R4 sel2");
      wr(8'h37);
      expect_req(1'b0, 256 * 16, "R4 sel7");
   endtask

   task automatic t_wrap();
      wr(8'h30);
      expect_req(1'b0, NS, "R9 first");
      expect_req(1'b0, NS - 1, "R9 second");
   endtask

   task automatic t_flag();
      chk("R7 flag set before writes", rd_s[7], 1'b1);
      wr(8'hB0);
      chk("R7 write one keeps flag", rd_s[7], 1'b1);
      chk("R5 restart bit reads zero", rd_s[4], 1'b0);
      wr(8'h30);
      chk("R7 write zero clears flag", rd_s[7], 1'b0);
      wr(8'hB0);
      chk("R7 write one does not set flag", rd_s[7], 1'b0);
   endtask

   task automatic t_restart();
      wr(8'h30);
      repeat (NS - 5) @(posedge clk);
      wr(8'h30);
      chk("R5 restart reg value", rd_s, 8'h20);
      expect_req(1'b0, NS, "R5 restart delays");
   endtask

   task automatic t_sticky();
      wr(8'h10);
      chk("R3 enable survives zero write", rd_s[5], 1'b1);
      expect_req(1'b0, NS, "R3 keeps counting");
   endtask

   task automatic t_tick();
      wr(8'h30);
      tick_en = 1'b0;
      repeat (50) @(posedge clk);
      @(negedge clk);
      chk("R10 no req without ticks", req_s, 1'b0);
      tick_en = 1'b1;
      expect_req(1'b0, NS, "R10 count resumes");
   endtask

   task automatic t_idle();
      cpu_idle = 1'b1;
      wr(8'h30);
      repeat (60) @(posedge clk);
      @(negedge clk);
      chk("R8 idle holds count", req_s, 1'b0);
      cpu_idle = 1'b0;
      expect_req(1'b0, NS, "R8 held then resumes");
      cpu_idle = 1'b1;
      wr(8'h38);
      expect_req(1'b0, NS, "R8 idle run counts");
      cpu_idle = 1'b0;
   endtask

   task automatic t_main();
      wr(8'h30);
      chk("R7 main flag clear", rd_m[7], 1'b0);
      expect_req(1'b1, 65536, "R4 main 15-bit");
      chk("R6 main flag set", rd_m[7], 1'b1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_power_on();
      t_disabled();
      t_ratio();
      t_wrap();
      t_flag();
      t_restart();
      t_sticky();
      t_tick();
      t_idle();
      t_main();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule